// File: doc/BRIEF.md
# Twisted-Ring Counter-Divider with Decoded Slots

This block counts clock edges in Johnson code. A shift register whose last bit feeds back inverted into its first bit steps through twice as many states as it has stages. The block decodes each state onto its own slot line, so a five-stage ring gives ten slot outputs and divides by ten, and a four-stage ring gives eight slot outputs and divides by eight. Only one ring bit changes on any step, and each slot decode looks at two neighbouring ring bits. The slot lines therefore switch without hazards.

The carry output is a square wave at the clock rate divided by the slot count. It can clock a further stage of the same kind. Counting is held off by an active-high inhibit input. An asynchronous active-high reset returns the ring to its zero count. If the ring ever holds a pattern outside the legal sequence, the next counting edge loads the zero count.

Top module: `johnson_divider`

## Requirements
- R1: While `rst` is 1, the ring is cleared at once without waiting for a clock edge. `slot` then equals 1 (bit 0 high) and `carry` is 1. Reset overrides `inhibit`.
- R2: On each rising edge of `clk` with `inhibit` at 0, the count k steps to (k+1) mod 2·STAGES, and `slot` shows bit k. For STAGES=5 the ring follows 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 and then returns to 00000.
- R3: On a rising edge with `inhibit` at 1, the count does not change, so `slot` and `carry` keep their values.
- R4: Whenever the ring holds a legal pattern, exactly one bit of `slot` is 1. That bit stays high for one full clock period per counting step.
- R5: `carry` is 1 for counts 0 to STAGES−1 and 0 for counts STAGES to 2·STAGES−1. It therefore rises exactly once, on entry to count 0, in every 2·STAGES counting edges, with a 50% duty cycle.
- R6: A ring pattern with more than one boundary between adjacent differing bits is illegal. On the next rising edge with `inhibit` at 0, such a pattern is replaced by count 0 (`slot` = 1, `carry` = 1).
- R7: With STAGES=4 the block has eight slot lines and divides by eight. `carry` is high for counts 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Asynchronous reset to count 0, active high |
| inhibit | input | 1 | Holds the count when 1 |
| slot | output | 2*STAGES | One-hot decoded count, bit k high during count k |
| carry | output | 1 | Divided clock, high for the first half of the cycle |

## Verification
The main function is exercised with three input patterns. An unbroken run of enabled edges spanning more than two full cycles checks that the slot order is correct and that the count wraps from the last slot back to slot 0. An irregular inhibit pattern mixed into counting exposes any edge that advances while it should hold, or holds while it should advance. A count of carry rising edges and high samples over whole cycles separates a true half-cycle square wave from a terminal-count pulse. Reset is asserted between clock edges in the middle of a count, to show that it acts without a clock. An illegal ring pattern is planted, to show that one counting edge brings the ring back into the sequence. The eight-slot variant runs beside the ten-slot one on the same stimulus, so any difference in wrap point or carry split between the two is exposed.

// File: rtl/johnson_divider.sv
`timescale 1ns/1ps
module johnson_divider #(
  parameter int STAGES = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inhibit,
  output logic [2*STAGES-1:0]   slot,
  output logic                  carry
);
  localparam int W = 2 * STAGES;

  logic [STAGES-1:0] ring;
  logic [STAGES-2:0] edges;
  logic              legal;
  logic [STAGES-1:0] ring_nxt;

  assign edges    = ring[STAGES-1:1] ^ ring[STAGES-2:0];
  assign legal    = (edges & (edges - 1'b1)) == '0;
  assign ring_nxt = legal ? {ring[STAGES-2:0], ~ring[STAGES-1]} : '0;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      ring <= '0;
    else if (!inhibit)
      ring <= ring_nxt;
  end

  assign slot[0]      = ~ring[STAGES-1] & ~ring[0];
  assign slot[STAGES] =  ring[STAGES-1] &  ring[0];

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_dec
      assign slot[k]          =  ring[k-1] & ~ring[k];
      assign slot[STAGES + k] = ~ring[k-1] &  ring[k];
    end
  endgenerate

  assign carry = ~ring[STAGES-1];
endmodule

module johnson_divider_chk #(
  parameter int STAGES = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                inhibit,
  input logic [2*STAGES-1:0] slot,
  input logic                carry
);
  localparam int W = 2 * STAGES;

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |-> (slot == W'(1) && carry));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!inhibit && $onehot(slot)) |=>
      (!$onehot(slot) || slot == $past({slot[W-2:0], slot[W-1]})));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> ($stable(slot) && $stable(carry)));

  a_r5_carry_half: assert property (@(posedge clk) disable iff (rst)
    $onehot(slot) |-> (carry == (|slot[STAGES-1:0])));

  a_r5_carry_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(carry) |-> slot[0]);

  a_r6_recover: assert property (@(posedge clk) disable iff (rst)
    (!inhibit && !$onehot(slot)) |=> (slot == W'(1) && carry));
endmodule

bind johnson_divider johnson_divider_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst(rst), .inhibit(inhibit), .slot(slot), .carry(carry)
);

// File: tb/johnson_divider_bench.sv
`timescale 1ns/1ps
module johnson_divider_bench;
  logic clk = 1'b0;
  logic rst = 1'b0;
  logic inhibit = 1'b1;
  logic [9:0] slot_a;
  logic       carry_a;
  logic [7:0] slot_b;
  logic       carry_b;

  int n_run = 0;
  int n_fail = 0;
  int exp_a = 0;
  int exp_b = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  johnson_divider #(.STAGES(5)) u_johnson_divider (
    .clk(clk), .rst(rst), .inhibit(inhibit), .slot(slot_a), .carry(carry_a)
  );

  johnson_divider #(.STAGES(4)) u_johnson_divider_oct (
    .clk(clk), .rst(rst), .inhibit(inhibit), .slot(slot_b), .carry(carry_b)
  );

  task automatic chk(string req, bit ok, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic check_both(string req);
    chk({req, " slot10"}, slot_a == 10'(1 << exp_a), int'(slot_a), 1 << exp_a);
    chk({req, "/R5 carry10"}, carry_a == (exp_a < 5), int'(carry_a), int'(exp_a < 5));
    chk({req, "/R7 slot8"}, slot_b == 8'(1 << exp_b), int'(slot_b), 1 << exp_b);
    chk({req, "/R7 carry8"}, carry_b == (exp_b < 4), int'(carry_b), int'(exp_b < 4));
  endtask

  task automatic tick(bit inh);
    inhibit = inh;
    @(posedge clk);
    if (!inh) begin
      exp_a = (exp_a + 1) % 10;
      exp_b = (exp_b + 1) % 8;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1 rst = 1'b1;
    #1;
    chk("R1 async slot", slot_a == 10'd1, int'(slot_a), 1);
    chk("R1 async carry", carry_a == 1'b1, int'(carry_a), 1);
    @(negedge clk);
    rst = 1'b0;
    exp_a = 0;
    exp_b = 0;
    check_both("R1");
    tick(1'b1);
    check_both("R1");
  endtask

  task automatic t_count();
    for (int i = 0; i < 25; i++) begin
      tick(1'b0);
      check_both("R2");
      chk("R4 onehot10", $countones(slot_a) == 1, $countones(slot_a), 1);
      chk("R4 onehot8", $countones(slot_b) == 1, $countones(slot_b), 1);
    end
  endtask

  task automatic t_inhibit();
    logic [19:0] pat = 20'b1011_0010_1110_0100_1101;
    for (int i = 0; i < 20; i++) begin
      tick(pat[i]);
      check_both("R3");
    end
  endtask

  task automatic t_carry();
    int rise_a = 0;
    int high_a = 0;
    int rise_b = 0;
    logic prev_a = carry_a;
    logic prev_b = carry_b;
    for (int i = 0; i < 30; i++) begin
      tick(1'b0);
      if (carry_a && !prev_a) rise_a++;
      if (carry_a) high_a++;
      if (i < 24 && carry_b && !prev_b) rise_b++;
      prev_a = carry_a;
      prev_b = carry_b;
    end
    chk("R5 rises10", rise_a == 3, rise_a, 3);
    chk("R5 duty10", high_a == 15, high_a, 15);
    chk("R7 rises8", rise_b == 3, rise_b, 3);
  endtask

  task automatic t_mid_reset();
    tick(1'b0);
    tick(1'b0);
    tick(1'b0);
    inhibit = 1'b0;
    #1 rst = 1'b1;
    #0.5;
    chk("R1 mid slot10", slot_a == 10'd1, int'(slot_a), 1);
    chk("R1 mid carry10", carry_a == 1'b1, int'(carry_a), 1);
    chk("R1 mid slot8", slot_b == 8'd1, int'(slot_b), 1);
    @(negedge clk);
    chk("R1 held slot10", slot_a == 10'd1, int'(slot_a), 1);
    rst = 1'b0;
    exp_a = 0;
    exp_b = 0;
    tick(1'b0);
    check_both("R1");
  endtask

  task automatic t_illegal();
    tick(1'b0);
    inhibit = 1'b0;
    force u_johnson_divider.ring = 5'b01010;
    #1 release u_johnson_divider.ring;
    #0.5;
    chk("R6 planted", $countones(slot_a) != 1, $countones(slot_a), 2);
    @(posedge clk);
    exp_a = 0;
    exp_b = (exp_b + 1) % 8;
    @(negedge clk);
    check_both("R6");
    tick(1'b0);
    check_both("R6");
  endtask

  initial begin
    t_reset();
    t_count();
    t_inhibit();
    t_carry();
    t_mid_reset();
    t_illegal();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule